// File: doc/BRIEF.md
# Multi-Region Erase Range Walker

This controller turns one erase request, given as a start offset and a byte length, into a series of single-block erase requests for a flash array. The array is described by a small region table. Each region has a start offset, a block size that is a power of two (stored as its log2), and a block count. The array is split into equal chips whose size is a power of two. The table is written through a simple indexed write port before any request is issued, and the regions must be listed in ascending start order.

When a request arrives, the walker finds the region that holds the start point and the region that holds the end point (start plus length). It rejects the request if either point is not aligned to the block size of its own region. If both are aligned, it emits one block request per block. Each block request carries the chip index, the address inside the chip and the block size. The walker holds each block request until it is acknowledged. The block size may change partway through a request, at a region boundary. The address rolls over into the next chip, and the walk stops early once it runs past the last chip. A failure flagged on any acknowledgement ends the walk at once. Completion is a one-cycle `done` pulse that comes with a result code.

Top module: `erase_range_walker`

## Requirements
- R1: After reset `busy`, `done` and `blk_req` are all low.
- R2: A table write with `cfg_we` high stores the start offset, size log2 and block count in entry `cfg_idx`, and that entry is used from the next request on.
- R3: The start region is the last entry in the sequence whose start is at or below the request start. If the request start is not a multiple of that region's block size, the walker finishes with code 1.
- R4: The end point (start plus length) selects its region by the same search. An end point that equals a region's start belongs to that region. If the end point is not a multiple of that region's block size, the walker finishes with code 2. Code 2 is checked only after the start check of R3 has passed.
- R5: If no region starts at or below the request start, or if the start offset shifted right by `CHIP_SHIFT` is `NCHIPS` or more, the walker finishes with code 4. Code 4 is checked before codes 1 and 2.
- R6: The first block request has `blk_chip` = start >> `CHIP_SHIFT` and `blk_addr` = start mod 2^`CHIP_SHIFT`.
- R7: Each block has the size of the current region (`blk_szlog`). After a block, the offset advances by that size. When the offset reaches the region start plus size times count, the walker moves to the next table entry; it stays on the last entry once it reaches it.
- R8: When the in-chip address plus the block size reaches 2^`CHIP_SHIFT`, the next block has address 0 in chip index plus one.
- R9: The walk ends with code 0 after the block whose size covers the remaining length, or after a rollover out of chip `NCHIPS`-1, whichever comes first.
- R10: `blk_req`, `blk_chip`, `blk_addr` and `blk_szlog` stay stable until a cycle with `blk_ack` high. The next block, if any, is presented in the following cycle.
- R11: An acknowledgement with `blk_fail` high ends the walk with code 3, and no further block is requested.
- R12: A request with zero length finishes with code 0 in the next cycle, without any table check.
- R13: `done` pulses high for one cycle. It comes one cycle after the accepting edge for a zero-length request, two cycles after it for a rejected request, and one cycle after the final acknowledging edge otherwise. `busy` is high from acceptance until that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Region table write strobe |
| cfg_idx | input | IDX_W | Table entry to write |
| cfg_start | input | ADDR_W | Region start offset |
| cfg_szlog | input | SZ_W | log2 of the region block size |
| cfg_count | input | CNT_W | Number of blocks in the region |
| req_valid | input | 1 | Erase request strobe, taken when not busy |
| req_start | input | ADDR_W | Erase start offset |
| req_len | input | ADDR_W | Erase length in bytes |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| done_code | output | 3 | 0 ok, 1 start misaligned, 2 end misaligned, 3 block failed, 4 out of range |
| blk_req | output | 1 | Block erase request |
| blk_chip | output | CHIP_W | Chip index of the block |
| blk_addr | output | CHIP_SHIFT | Address of the block inside the chip |
| blk_szlog | output | SZ_W | log2 of the block size |
| blk_ack | input | 1 | Block request accepted and finished |
| blk_fail | input | 1 | Qualifies `blk_ack`: the block failed |

## Verification
The first block appears two cycles after the accepting edge, because one cycle goes to the region search. A rejection is due at that same point, and a zero-length completion one cycle earlier. Each later block, and the final `done`, is due one cycle after the acknowledging edge. The bench drives inputs and samples outputs on the falling edge and counts falling edges from the request. At each one it compares the outputs with a queue of expected blocks built by a behavioural model, and it checks that `done` arrives on exactly the count the model predicts. Acknowledgements are delayed by 0 to 2 cycles, so the hold-until-ack behaviour is exercised on every walk.

// File: rtl/ers_pkg.sv
package ers_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_CHECK = 2'd1,
      ST_ISSUE = 2'd2
   } ers_state_e;

   typedef enum logic [2:0] {
      ERS_OK             = 3'd0,
      ERS_START_MISALIGN = 3'd1,
      ERS_END_MISALIGN   = 3'd2,
      ERS_BLOCK_FAIL     = 3'd3,
      ERS_OUT_OF_RANGE   = 3'd4
   } ers_code_e;

endpackage

// File: rtl/ers_region_table.sv
module ers_region_table #(
   parameter int NREG   = 4,
   parameter int ADDR_W = 16,
   parameter int SZ_W   = 4,
   parameter int CNT_W  = 8,
   parameter int IDX_W  = 2
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr_en,
   input  logic [IDX_W-1:0]                  wr_idx,
   input  logic [ADDR_W-1:0]                 wr_start,
   input  logic [SZ_W-1:0]                   wr_szlog,
   input  logic [CNT_W-1:0]                  wr_count,
   output logic [NREG-1:0][ADDR_W-1:0]       tbl_start,
   output logic [NREG-1:0][SZ_W-1:0]         tbl_szlog,
   output logic [NREG-1:0][CNT_W-1:0]        tbl_count
);

   for (genvar g = 0; g < NREG; g++) begin : g_entry
      logic sel;
      assign sel = wr_en && (wr_idx == IDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tbl_start[g] <= '0;
            tbl_szlog[g] <= '0;
            tbl_count[g] <= '0;
         end else if (sel) begin
            tbl_start[g] <= wr_start;
            tbl_szlog[g] <= wr_szlog;
            tbl_count[g] <= wr_count;
         end
      end

      // R2: a write lands in its entry on the next cycle
      a_r2_entry_written: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wr_idx == IDX_W'(g)) |=>
            (tbl_start[g] == $past(wr_start) && tbl_szlog[g] == $past(wr_szlog)
             && tbl_count[g] == $past(wr_count)));

      // R2: entries other than the one written keep their content
      a_r2_entry_kept: assert property (@(posedge clk) disable iff (!rst_n)
         !(wr_en && wr_idx == IDX_W'(g)) |=> $stable(tbl_start[g]));
   end

endmodule

// File: rtl/ers_region_find.sv
module ers_region_find #(
   parameter int NREG   = 4,
   parameter int ADDR_W = 16,
   parameter int IDX_W  = 2
) (
   input  logic [ADDR_W:0]             point,
   input  logic [NREG-1:0][ADDR_W-1:0] starts,
   output logic [IDX_W-1:0]            idx,
   output logic                        hit
);

   // Walk the table while entries start at or below the point; the last
   // entry passed is the containing region.
   logic [NREG-1:0] at_or_below;

   for (genvar g = 0; g < NREG; g++) begin : g_cmp
      assign at_or_below[g] = (point >= {1'b0, starts[g]});
   end

   always_comb begin
      logic stop;
      stop = 1'b0;
      idx  = '0;
      hit  = 1'b0;
      for (int i = 0; i < NREG; i++) begin
         if (!stop && at_or_below[i]) begin
            idx = IDX_W'(i);
            hit = 1'b1;
         end else begin
            stop = 1'b1;
         end
      end
   end

endmodule

// File: rtl/ers_chip_cursor.sv
module ers_chip_cursor #(
   parameter int ADDR_W     = 16,
   parameter int CHIP_SHIFT = 12,
   parameter int NCHIPS     = 4,
   parameter int CHIP_W     = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          load,
   input  logic [CHIP_SHIFT+CHIP_W-1:0]  load_ofs,
   input  logic                          step,
   input  logic [ADDR_W:0]               step_size,
   output logic [CHIP_W-1:0]             chip,
   output logic [CHIP_SHIFT-1:0]         addr,
   output logic                          wrap_last
);

   localparam int SUM_W = ADDR_W + 1;

   logic [CHIP_SHIFT-1:0] addr_q;
   logic [SUM_W-1:0]      sum;
   logic                  overflow;

   assign sum      = {{(SUM_W-CHIP_SHIFT){1'b0}}, addr_q} + step_size;
   assign overflow = |sum[SUM_W-1:CHIP_SHIFT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else if (load) begin
         addr_q <= load_ofs[CHIP_SHIFT-1:0];
      end else if (step) begin
         addr_q <= overflow ? '0 : sum[CHIP_SHIFT-1:0];
      end
   end

   assign addr = addr_q;

   if (NCHIPS > 1) begin : g_multi
      logic [CHIP_W-1:0] chip_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chip_q <= '0;
         end else if (load) begin
            chip_q <= load_ofs[CHIP_SHIFT +: CHIP_W];
         end else if (step && overflow) begin
            chip_q <= chip_q + CHIP_W'(1);
         end
      end

      assign chip      = chip_q;
      assign wrap_last = overflow && (chip_q == CHIP_W'(NCHIPS - 1));

      // R8: overflow of the in-chip address moves to address 0 of the next chip
      a_r8_chip_rollover: assert property (@(posedge clk) disable iff (!rst_n)
         (step && !load && overflow) |=>
            (addr_q == '0 && chip_q == $past(chip_q) + CHIP_W'(1)));

      // R6: a load splits the offset into chip index and in-chip address
      a_r6_offset_split: assert property (@(posedge clk) disable iff (!rst_n)
         load |=> (addr_q == $past(load_ofs[CHIP_SHIFT-1:0])
                   && chip_q == $past(load_ofs[CHIP_SHIFT +: CHIP_W])));
   end else begin : g_single
      logic unused_hi;
      assign unused_hi = |load_ofs[CHIP_SHIFT +: CHIP_W];
      assign chip      = '0;
      assign wrap_last = overflow;
   end

endmodule

// File: rtl/erase_range_walker.sv
module erase_range_walker #(
   parameter int NREG       = 4,
   parameter int ADDR_W     = 16,
   parameter int CHIP_SHIFT = 12,
   parameter int NCHIPS     = 4,
   parameter int SZ_W       = 4,
   parameter int CNT_W      = 8,
   localparam int IDX_W     = (NREG > 1) ? $clog2(NREG) : 1,
   localparam int CHIP_W    = (NCHIPS > 1) ? $clog2(NCHIPS) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_we,
   input  logic [IDX_W-1:0]      cfg_idx,
   input  logic [ADDR_W-1:0]     cfg_start,
   input  logic [SZ_W-1:0]       cfg_szlog,
   input  logic [CNT_W-1:0]      cfg_count,
   input  logic                  req_valid,
   input  logic [ADDR_W-1:0]     req_start,
   input  logic [ADDR_W-1:0]     req_len,
   output logic                  busy,
   output logic                  done,
   output logic [2:0]            done_code,
   output logic                  blk_req,
   output logic [CHIP_W-1:0]     blk_chip,
   output logic [CHIP_SHIFT-1:0] blk_addr,
   output logic [SZ_W-1:0]       blk_szlog,
   input  logic                  blk_ack,
   input  logic                  blk_fail
);
   import ers_pkg::*;

   localparam int EXT_W  = ADDR_W + 1;
   localparam int SPAN_W = EXT_W + CNT_W;
   localparam int HI_W   = EXT_W - CHIP_SHIFT;
   localparam logic [HI_W-1:0]  NCHIPS_V = HI_W'(NCHIPS);
   localparam logic [IDX_W-1:0] LAST_REG = IDX_W'(NREG - 1);

   // elaboration-time parameter checks
   if (NREG < 1) begin : g_bad_nreg
      $error("erase_range_walker: NREG must be at least 1");
   end
   if (CHIP_SHIFT < 1 || CHIP_SHIFT + CHIP_W > ADDR_W) begin : g_bad_chip
      $error("erase_range_walker: chip field does not fit in ADDR_W");
   end
   if ((2 ** SZ_W) - 1 > ADDR_W) begin : g_bad_sz
      $error("erase_range_walker: SZ_W allows blocks wider than the offset");
   end

   ers_state_e state_q;
   ers_code_e  code_q;
   logic                  done_q;
   logic [EXT_W-1:0]      ofs_q;
   logic [EXT_W-1:0]      rem_q;
   logic [IDX_W-1:0]      ridx_q;

   logic [NREG-1:0][ADDR_W-1:0] tbl_start;
   logic [NREG-1:0][SZ_W-1:0]   tbl_szlog;
   logic [NREG-1:0][CNT_W-1:0]  tbl_count;

   ers_region_table #(
      .NREG(NREG), .ADDR_W(ADDR_W), .SZ_W(SZ_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
   ) i_table (
      .clk(clk), .rst_n(rst_n),
      .wr_en(cfg_we), .wr_idx(cfg_idx), .wr_start(cfg_start),
      .wr_szlog(cfg_szlog), .wr_count(cfg_count),
      .tbl_start(tbl_start), .tbl_szlog(tbl_szlog), .tbl_count(tbl_count)
   );

   // region search for both endpoints
   logic [EXT_W-1:0] end_pt;
   logic [IDX_W-1:0] a_idx, b_idx;
   logic             a_hit, b_hit;

   assign end_pt = ofs_q + rem_q;

   ers_region_find #(.NREG(NREG), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_find_start (
      .point(ofs_q), .starts(tbl_start), .idx(a_idx), .hit(a_hit)
   );

   ers_region_find #(.NREG(NREG), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_find_end (
      .point(end_pt), .starts(tbl_start), .idx(b_idx), .hit(b_hit)
   );

   logic [EXT_W-1:0] sz_a, sz_b;
   logic             misalign_a, misalign_b, range_bad;

   assign sz_a       = EXT_W'(1) << tbl_szlog[a_idx];
   assign sz_b       = EXT_W'(1) << tbl_szlog[b_idx];
   assign misalign_a = |(ofs_q & (sz_a - EXT_W'(1)));
   assign misalign_b = |(end_pt & (sz_b - EXT_W'(1)));
   assign range_bad  = !a_hit || !b_hit || (ofs_q[EXT_W-1:CHIP_SHIFT] >= NCHIPS_V);

   // current region geometry
   logic [SZ_W-1:0]   cur_log;
   logic [EXT_W-1:0]  cur_size;
   logic [EXT_W-1:0]  ofs_next;
   logic [SPAN_W-1:0] reg_end;
   logic              region_hit;
   logic              wrap_last;
   logic              last_blk;
   logic              step;

   assign cur_log    = tbl_szlog[ridx_q];
   assign cur_size   = EXT_W'(1) << cur_log;
   assign ofs_next   = ofs_q + cur_size;
   assign reg_end    = SPAN_W'(tbl_start[ridx_q]) + (SPAN_W'(tbl_count[ridx_q]) << cur_log);
   assign region_hit = (SPAN_W'(ofs_next) == reg_end);
   assign last_blk   = (rem_q <= cur_size) || wrap_last;
   assign step       = (state_q == ST_ISSUE) && blk_ack;

   ers_chip_cursor #(
      .ADDR_W(ADDR_W), .CHIP_SHIFT(CHIP_SHIFT), .NCHIPS(NCHIPS), .CHIP_W(CHIP_W)
   ) i_cursor (
      .clk(clk), .rst_n(rst_n),
      .load(state_q == ST_CHECK),
      .load_ofs(ofs_q[CHIP_SHIFT+CHIP_W-1:0]),
      .step(step),
      .step_size(cur_size),
      .chip(blk_chip),
      .addr(blk_addr),
      .wrap_last(wrap_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         code_q  <= ERS_OK;
         done_q  <= 1'b0;
         ofs_q   <= '0;
         rem_q   <= '0;
         ridx_q  <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  if (req_len == '0) begin
                     done_q <= 1'b1;
                     code_q <= ERS_OK;
                  end else begin
                     ofs_q   <= {1'b0, req_start};
                     rem_q   <= {1'b0, req_len};
                     state_q <= ST_CHECK;
                  end
               end
            end
            ST_CHECK: begin
               if (range_bad || misalign_a || misalign_b) begin
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
                  code_q  <= range_bad  ? ERS_OUT_OF_RANGE :
                             misalign_a ? ERS_START_MISALIGN : ERS_END_MISALIGN;
               end else begin
                  ridx_q  <= a_idx;
                  state_q <= ST_ISSUE;
               end
            end
            ST_ISSUE: begin
               if (blk_ack) begin
                  if (blk_fail || last_blk) begin
                     done_q  <= 1'b1;
                     state_q <= ST_IDLE;
                     code_q  <= blk_fail ? ERS_BLOCK_FAIL : ERS_OK;
                  end else begin
                     ofs_q <= ofs_next;
                     rem_q <= rem_q - cur_size;
                     if (region_hit && ridx_q != LAST_REG) begin
                        ridx_q <= ridx_q + IDX_W'(1);
                     end
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy      = (state_q != ST_IDLE);
   assign blk_req   = (state_q == ST_ISSUE);
   assign blk_szlog = cur_log;
   assign done      = done_q;
   assign done_code = code_q;

   // R10: a pending block request holds its fields until acknowledged
   a_r10_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_req && !blk_ack) |=>
         (blk_req && $stable(blk_chip) && $stable(blk_addr) && $stable(blk_szlog)));

   // R11: a failed block ends the walk with code 3 and no further request
   a_r11_fail_aborts: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_req && blk_ack && blk_fail) |=> (done && done_code == 3'd3 && !blk_req));

   // R12: a zero-length request completes successfully in the next cycle
   a_r12_zero_length: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy && req_len == '0) |=> (done && done_code == 3'd0));

   // R13: the completion pulse lasts one cycle and comes with the walker idle
   a_r13_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r13_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && !blk_req));

   // R4/R3: a block request never follows a check cycle with a rejection
   a_r3_no_issue_after_reject: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !blk_req && $past(!busy) && $past(req_valid)) |=> (blk_req || done));

endmodule

// File: tb/test_erase_range_walker.sv
module test_erase_range_walker;

   localparam int NREG       = 4;
   localparam int ADDR_W     = 16;
   localparam int CHIP_SHIFT = 12;
   localparam int NCHIPS     = 4;
   localparam int SZ_W       = 4;
   localparam int CNT_W      = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_we = 1'b0;
   logic [1:0] cfg_idx = '0;
   logic [ADDR_W-1:0] cfg_start = '0;
   logic [SZ_W-1:0] cfg_szlog = '0;
   logic [CNT_W-1:0] cfg_count = '0;
   logic req_valid = 1'b0;
   logic [ADDR_W-1:0] req_start = '0;
   logic [ADDR_W-1:0] req_len = '0;
   logic busy, done;
   logic [2:0] done_code;
   logic blk_req;
   logic [1:0] blk_chip;
   logic [CHIP_SHIFT-1:0] blk_addr;
   logic [SZ_W-1:0] blk_szlog;
   logic blk_ack = 1'b0;
   logic blk_fail = 1'b0;

   always #5 clk = ~clk;

   erase_range_walker #(
      .NREG(NREG), .ADDR_W(ADDR_W), .CHIP_SHIFT(CHIP_SHIFT),
      .NCHIPS(NCHIPS), .SZ_W(SZ_W), .CNT_W(CNT_W)
   ) i_erase_range_walker (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_start(cfg_start),
      .cfg_szlog(cfg_szlog), .cfg_count(cfg_count),
      .req_valid(req_valid), .req_start(req_start), .req_len(req_len),
      .busy(busy), .done(done), .done_code(done_code),
      .blk_req(blk_req), .blk_chip(blk_chip), .blk_addr(blk_addr),
      .blk_szlog(blk_szlog), .blk_ack(blk_ack), .blk_fail(blk_fail)
   );

   int n_checks = 0;
   int n_fails  = 0;

   // behavioural model of the region table
   int m_start[NREG];
   int m_log[NREG];
   int m_cnt[NREG];
   int q_chip[$];
   int q_addr[$];
   int q_log[$];
   int exp_code;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic load_region(input int idx, input int st, input int lg, input int cnt);
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = 2'(idx); cfg_start = 16'(st);
      cfg_szlog = 4'(lg); cfg_count = 8'(cnt);
      @(negedge clk);
      cfg_we = 1'b0;
      m_start[idx] = st; m_log[idx] = lg; m_cnt[idx] = cnt;
   endtask

   function automatic int find_region(input int p);
      int i = 0;
      while (i < NREG && p >= m_start[i]) i++;
      return i - 1;
   endfunction

   task automatic model(input int s, input int len, input int fail_at);
      int r, e, j, chip, a, o, rem, sz;
      q_chip.delete(); q_addr.delete(); q_log.delete();
      exp_code = 0;
      if (len == 0) return;
      r = find_region(s);
      e = s + len;
      j = find_region(e);
      if (r < 0 || (s >> CHIP_SHIFT) >= NCHIPS) begin exp_code = 4; return; end
      if (s % (1 << m_log[r]) != 0) begin exp_code = 1; return; end
      if (e % (1 << m_log[j]) != 0) begin exp_code = 2; return; end
      chip = s >> CHIP_SHIFT; a = s % (1 << CHIP_SHIFT); o = s; rem = len;
      while (rem > 0) begin
         sz = 1 << m_log[r];
         q_chip.push_back(chip); q_addr.push_back(a); q_log.push_back(m_log[r]);
         a += sz; o += sz;
         rem = (rem <= sz) ? 0 : rem - sz;
         if (o == m_start[r] + sz * m_cnt[r] && r < NREG - 1) r++;
         if (a >= (1 << CHIP_SHIFT)) begin
            a = 0; chip++;
            if (chip >= NCHIPS) break;
         end
      end
      if (fail_at >= 0 && fail_at < q_chip.size()) begin
         while (q_chip.size() > fail_at + 1) begin
            void'(q_chip.pop_back()); void'(q_addr.pop_back()); void'(q_log.pop_back());
         end
         exp_code = 3;
      end
   endtask

   // issue one request and compare against the model on every falling edge
   task automatic run(input string tag, input int s, input int len, input int fail_at);
      int n, k, w, last_ack, due;
      bit fin;
      model(s, len, fail_at);
      @(negedge clk);
      req_valid = 1'b1; req_start = 16'(s); req_len = 16'(len);
      n = 0; k = 0; w = 0; last_ack = -1; fin = 0;
      while (!fin) begin
         @(negedge clk);
         n++;
         req_valid = 1'b0; blk_ack = 1'b0; blk_fail = 1'b0;
         if (done) begin
            // R13: completion due at a fixed distance from the stimulus
            if (len == 0) due = 1;
            else if (exp_code == 1 || exp_code == 2 || exp_code == 4) due = 2;
            else due = last_ack + 1;
            chk(n == due, {tag, " R13 done cycle"}, n, due);
            chk(int'(done_code) == exp_code, {tag, " done_code"}, int'(done_code), exp_code);
            chk(q_chip.size() == 0, {tag, " R9 all blocks issued"}, q_chip.size(), 0);
            fin = 1;
         end else if (blk_req) begin
            if (q_chip.size() == 0) begin
               chk(1'b0, {tag, " R11 unexpected block"}, int'(blk_addr), -1);
            end else begin
               // R6 R7 R8 R10: block fields against the model, every cycle
               chk(int'(blk_chip) == q_chip[0], {tag, " R6 R8 blk_chip"}, int'(blk_chip), q_chip[0]);
               chk(int'(blk_addr) == q_addr[0], {tag, " R6 R8 blk_addr"}, int'(blk_addr), q_addr[0]);
               chk(int'(blk_szlog) == q_log[0], {tag, " R7 blk_szlog"}, int'(blk_szlog), q_log[0]);
               if (w >= k % 3) begin
                  blk_ack = 1'b1;
                  blk_fail = (k == fail_at);
                  void'(q_chip.pop_front()); void'(q_addr.pop_front()); void'(q_log.pop_front());
                  k++; w = 0; last_ack = n;
               end else begin
                  w++;
               end
            end
         end else begin
            // R13: only the search cycle may be busy without a block
            chk(n == 1 && busy, {tag, " R13 search cycle"}, n, 1);
         end
         if (n > 400) begin
            chk(1'b0, {tag, " R13 no completion"}, n, 400);
            fin = 1;
         end
      end
      @(negedge clk);
      chk(!busy && !blk_req && !done, {tag, " R11 R13 idle after done"},
          int'({busy, blk_req, done}), 0);
   endtask

   initial begin : watchdog
      repeat (60000) @(posedge clk);
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(!busy && !done && !blk_req, "R1 reset outputs", int'({busy, done, blk_req}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !blk_req, "R1 after release", int'({busy, done, blk_req}), 0);

      // R2: table: 256 B x4 @0, 1 KiB x6 @0x400, 512 B x10 @0x1C00, 2 KiB x2 @0x3000
      load_region(0, 'h0000, 8, 4);
      load_region(1, 'h0400, 10, 6);
      load_region(2, 'h1C00, 9, 10);
      load_region(3, 'h3000, 11, 2);

      run("R6 single block",        'h0300, 'h0100, -1);
      run("R7 size change",         'h0300, 'h0500, -1);
      run("R4 end misaligned",      'h0300, 'h0200, -1);
      run("R3 start misaligned",    'h0500, 'h0400, -1);
      run("R8 chip rollover",       'h0C00, 'h0800, -1);
      run("R9 early end last chip", 'h3000, 'h2000, -1);
      run("R5 chip out of range",   'h4000, 'h0800, -1);
      run("R12 zero length",        'h0123, 'h0000, -1);
      run("R11 block failure",      'h1C00, 'h0800, 1);
      run("R7 region 1 to 2",       'h1800, 'h0600, -1);
      run("R4 end on boundary",     'h2E00, 'h0200, -1);
      run("R7 R8 long walk",        'h0000, 'h3000, -1);
      run("R11 fail first block",   'h0000, 'h0100, 0);

      // R2 R5: move region 0 up so a start below it is rejected
      load_region(0, 'h0100, 8, 3);
      run("R5 below first region",  'h0000, 'h0100, -1);
      run("R2 reloaded entry",      'h0100, 'h0300, -1);

      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end

endmodule